// File: doc/BRIEF.md
# GF(4096) Tower Field Multiplier

This block multiplies two elements of the finite field GF(2^12) and returns their 12-bit product. The field is not held in a single degree-12 polynomial basis. Each element is a pair of GF(64) digits: bits 11:6 hold the high digit and bits 5:0 hold the low digit. GF(64) is reduced by x^6 + x + 1. The outer field is GF(64)[X]/(X^2 + X + A^-1), where A^-1 is the GF(64) constant 0x21. A full product needs three GF(64) multiplications plus one multiplication by that constant. Each GF(64) multiplication is unrolled into six shift-and-XOR stages.

A step mode multiplies the first operand by the fixed generator 0xE01 and ignores the second operand. An input of zero maps to one in this mode. Feeding each result back as the next input walks the powers of the generator, which is how log and antilog tables for a Reed-Solomon codec over this field can be built.

With the default parameter, the block has one register stage with a valid/ready handshake at both ends. With PIPELINED set to 0, the same arithmetic is purely combinational and the handshake signals pass straight through.

Top module: `gf4096_tower_mul`

## Requirements
- R1: While reset is asserted and in the first cycle after it, out_valid is 0 and in_ready is 1.
- R2: When both operands have a zero high digit, the product has a zero high digit, and its low digit is the GF(64) product under x^6 + x + 1. For example, 0x020 times 0x002 gives 0x003.
- R3: For operands a = {ah,al} and b = {bh,bl}, the high digit of the product is m(ah^al, bh^bl) ^ m(al,bl) and the low digit is m(m(ah,bh), 0x21) ^ m(al,bl), where m is the GF(64) product. For example, 0x040 times 0x040 gives 0x061.
- R4: 0x001 is the multiplicative identity on either side, and a zero operand gives a zero product.
- R5: The product does not depend on operand order.
- R6: In step mode (step_mode = 1), a nonzero op_a gives op_a times 0xE01, and op_b has no effect.
- R7: In step mode, an op_a of zero gives 0x001.
- R8: Stepping repeatedly from 0x001 returns to 0x001 after exactly 4095 steps and at no earlier step.
- R9: An input is taken when in_valid and in_ready are both high. in_ready is high when no result is held or when the held result is being taken. While out_valid is high and out_ready is low, out_valid and product stay unchanged.
- R10: An input taken at a clock edge appears on product with out_valid high right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands are presented |
| in_ready | output | 1 | Block can take operands this cycle |
| step_mode | input | 1 | 1 = multiply op_a by the generator, 0 = op_a times op_b |
| op_a | input | 12 | First operand, {high digit, low digit} |
| op_b | input | 12 | Second operand, ignored in step mode |
| out_valid | output | 1 | product holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| product | output | 12 | Field product |

## Verification
Operands with a zero high digit test only the GF(64) layer and its reduction. They show whether the 0x43 fold is right before the quadratic extension is involved. Operands with a nonzero high digit, such as X times X, test the A^-1 term and the cross products. A mirrored pair and a unit operand show whether digits are swapped or misrouted. The full 4095-step walk from one, with a changing op_b and intermittent back-pressure, tests the generator constant, the zero-to-one rule, and result holding in one pass: a single wrong bit anywhere breaks the cycle length.

// File: rtl/gf4096_tower_mul.sv
module gf4096_tower_mul #(
  parameter int          PIPELINED  = 1,
  parameter logic [11:0] STEP_CONST = 12'hE01,
  parameter logic [5:0]  INV_ROOT   = 6'h21
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic        step_mode,
  input  logic [11:0] op_a,
  input  logic [11:0] op_b,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [11:0] product
);
  localparam int HW = 6;
  localparam int W  = 2 * HW;
  localparam logic [HW:0] FOLD = 7'h43;

  function automatic logic [HW-1:0] base_mul(input logic [HW-1:0] x, input logic [HW-1:0] y);
    logic [HW-1:0] acc;
    logic [HW-1:0] sh;
    logic [HW:0]   nx;
    acc = '0;
    sh  = y;
    for (int i = 0; i < HW; i++) begin
      if (x[i]) acc = acc ^ sh;
      nx = {sh, 1'b0};
      if (nx[HW]) nx = nx ^ FOLD;
      sh = nx[HW-1:0];
    end
    return acc;
  endfunction

  logic [W-1:0]  rhs;
  logic [HW-1:0] ah, al, bh, bl, lo_prod, hi_digit, lo_digit;
  logic [W-1:0]  result;

  assign rhs      = step_mode ? STEP_CONST : op_b;
  assign ah       = op_a[W-1:HW];
  assign al       = op_a[HW-1:0];
  assign bh       = rhs[W-1:HW];
  assign bl       = rhs[HW-1:0];
  assign lo_prod  = base_mul(al, bl);
  assign hi_digit = base_mul(ah ^ al, bh ^ bl) ^ lo_prod;
  assign lo_digit = base_mul(base_mul(ah, bh), INV_ROOT) ^ lo_prod;
  assign result   = (step_mode && op_a == '0) ? W'(1) : {hi_digit, lo_digit};

  if (PIPELINED != 0) begin : g_reg
    assign in_ready = !out_valid || out_ready;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        out_valid <= 1'b0;
        product   <= '0;
      end else if (in_ready) begin
        out_valid <= in_valid;
        if (in_valid) product <= result;
      end
    end
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign product   = result;
  end
endmodule

// File: rtl/gf4096_tower_mul_chk.sv
module gf4096_tower_mul_chk #(
  parameter int PIPELINED = 1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        step_mode,
  input logic [11:0] op_a,
  input logic [11:0] op_b,
  input logic        out_valid,
  input logic        out_ready,
  input logic [11:0] product
);
  if (PIPELINED != 0) begin : g_chk
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !out_valid);
    assert_unit_right_R4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && !step_mode && op_b == 12'h001 |=> product == $past(op_a));
    assert_zero_left_R4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && !step_mode && op_a == 12'h000 |=> product == 12'h000);
    assert_step_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && step_mode && op_a == 12'h000 |=> product == 12'h001);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(product));
    assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid);
  end
endmodule

bind gf4096_tower_mul gf4096_tower_mul_chk #(.PIPELINED(PIPELINED)) u_chk (.*);

// File: tb/tb_gf4096_tower_mul.sv
module tb_gf4096_tower_mul;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        step_mode = 1'b0;
  logic [11:0] op_a = '0;
  logic [11:0] op_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [11:0] product;

  int n_checks = 0;
  int n_errors = 0;
  logic bp_en = 1'b0;
  int cyc_cnt = 0;
  logic [11:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gf4096_tower_mul dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .step_mode(step_mode), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .out_ready(out_ready), .product(product)
  );

  function automatic logic [5:0] ref64(input logic [5:0] x, input logic [5:0] y);
    logic [10:0] p;
    p = '0;
    for (int i = 0; i < 6; i++)
      if (y[i]) p = p ^ (11'(x) << i);
    for (int k = 10; k >= 6; k--)
      if (p[k]) p = p ^ ((11'h1 << k) | (11'h1 << (k-5)) | (11'h1 << (k-6)));
    return p[5:0];
  endfunction

  function automatic logic [11:0] ref_mul(input logic [11:0] a, input logic [11:0] b);
    logic [5:0] hi, lo;
    hi = ref64(a[11:6] ^ a[5:0], b[11:6] ^ b[5:0]) ^ ref64(a[5:0], b[5:0]);
    lo = ref64(ref64(a[11:6], b[11:6]), 6'h21) ^ ref64(a[5:0], b[5:0]);
    return {hi, lo};
  endfunction

  function automatic logic [11:0] ref_step(input logic [11:0] a);
    return (a == 12'h000) ? 12'h001 : ref_mul(a, 12'hE01);
  endfunction

  task automatic check(input logic ok, input string req, input logic [11:0] act, input logic [11:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %03h expected %03h", req, act, exp);
    end
  endtask

  task automatic send(input logic sm, input logic [11:0] a, input logic [11:0] b,
                      input logic [11:0] exp, input string tag);
    in_valid  = 1'b1;
    step_mode = sm;
    op_a      = a;
    op_b      = b;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    #1;
    cyc_cnt++;
    out_ready = !bp_en || (cyc_cnt % 3 != 0);
  end

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected result", product, 12'h000);
      end else begin
        logic [11:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(product == e, t, product, e);
      end
    end
  end

  logic        prev_stall = 1'b0;
  logic [11:0] prev_prod = '0;
  always @(negedge clk) begin
    if (rst_n && prev_stall)
      check(out_valid && product == prev_prod, "R9 hold", product, prev_prod);
    prev_stall = rst_n && out_valid && !out_ready;
    prev_prod  = product;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [11:0] x;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!out_valid, "R1 out_valid in reset", {11'b0, out_valid}, 12'h000);
    check(in_ready, "R1 in_ready in reset", {11'b0, in_ready}, 12'h001);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R1 after reset", {10'b0, out_valid, in_ready}, 12'h001);
    @(posedge clk); #1;

    // R10: latency with no back-pressure
    in_valid = 1'b1; step_mode = 1'b0; op_a = 12'h005; op_b = 12'h001;
    exp_q.push_back(12'h005); tag_q.push_back("R10");
    @(negedge clk);
    check(in_ready, "R10 ready", {11'b0, in_ready}, 12'h001);
    @(posedge clk); #1; in_valid = 1'b0;
    @(negedge clk);
    check(out_valid && product == 12'h005, "R10 latency", product, 12'h005);
    @(negedge clk);
    check(!out_valid, "R10 idle after transfer", {11'b0, out_valid}, 12'h000);
    @(posedge clk); #1;

    // R2: base field only
    send(1'b0, 12'h020, 12'h002, 12'h003, "R2");
    send(1'b0, 12'h03F, 12'h03F, {6'h00, ref64(6'h3F, 6'h3F)}, "R2");
    send(1'b0, 12'h013, 12'h02A, {6'h00, ref64(6'h13, 6'h2A)}, "R2");

    // R3: extension term
    send(1'b0, 12'h040, 12'h040, 12'h061, "R3");
    send(1'b0, 12'hABC, 12'h123, ref_mul(12'hABC, 12'h123), "R3");
    send(1'b0, 12'hFFF, 12'hFFF, ref_mul(12'hFFF, 12'hFFF), "R3");
    send(1'b0, 12'h801, 12'h7C0, ref_mul(12'h801, 12'h7C0), "R3");

    // R4: identity and zero
    send(1'b0, 12'h9E7, 12'h001, 12'h9E7, "R4");
    send(1'b0, 12'h001, 12'h5A3, 12'h5A3, "R4");
    send(1'b0, 12'h000, 12'hD42, 12'h000, "R4");
    send(1'b0, 12'h6B1, 12'h000, 12'h000, "R4");

    bp_en = 1'b1;
    // R5: operand order
    for (int i = 0; i < 8; i++) begin
      logic [11:0] a, b;
      a = 12'(i * 517 + 29);
      b = 12'(i * 1303 + 4001);
      send(1'b0, a, b, ref_mul(a, b), "R5");
      send(1'b0, b, a, ref_mul(a, b), "R5");
    end

    // R6 / R7: step mode
    send(1'b1, 12'h001, 12'h000, 12'hE01, "R6");
    send(1'b1, 12'h2C5, 12'hFFF, ref_mul(12'h2C5, 12'hE01), "R6");
    send(1'b1, 12'h2C5, 12'h111, ref_mul(12'h2C5, 12'hE01), "R6");
    send(1'b1, 12'h000, 12'h7AB, 12'h001, "R7");
    send(1'b1, 12'h000, 12'h000, 12'h001, "R7");

    // R8: generator walk
    x = 12'h001;
    for (int n = 1; n <= 4095; n++) begin
      logic [11:0] e;
      e = ref_step(x);
      send(1'b1, x, 12'(n * 37), e, "R8");
      x = e;
      if (x == 12'h001 && n < 4095)
        check(1'b0, "R8 early return", 12'(n), 12'd4095);
    end
    check(x == 12'h001, "R8 period", x, 12'h001);

    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule